// File: doc/BRIEF.md
# Accelerator Control Register Slave

This block is the host-facing register file of a compute kernel, reached over an AXI4-Lite slave port. The host uses it to launch the kernel, watch its progress, pick up completion and arm or clear an interrupt. It also holds the kernel's call arguments: 32-bit scalars and 64-bit buffer offsets, each offset stored as two consecutive 32-bit words.

The kernel datapath sees a start level and a one-cycle continue pulse from the block. It reports back with a one-cycle done pulse and live idle and ready levels. Some register bits change state when the bus touches them. In the sequential variant, a read of the control word clears the done flag. In the chained variant, the host clears done by writing the continue bit. Writing 1 to the interrupt status bit toggles it. The start flag drops only on a done pulse. When the auto-restart bit is set, start stays up across done instead. The variant is fixed by a parameter.

All state is reset by an active-low reset that is synchronous to the clock. The reset is registered once inside the block before it is used.

Top module: `accel_ctrl_slave`

## Requirements
- R1: After reset every stored bit is zero: `k_start`, `k_continue` and `irq` are low, the argument outputs are zero, and the words at 0x4, 0x8 and 0xC read 0. The control word at 0x0 then reads only the live idle bit.
- R2: A write to 0x0 with byte strobe 0 set and data bit 0 equal to 1 sets the start flag. `k_start` is high from the clock edge that accepts the write. Writing 0 to bit 0, or writing with strobe 0 clear, leaves the flag unchanged.
- R3: A `k_done` pulse clears the start flag at the same edge, unless auto-restart (control bit 7, read/write) is 1, in which case start stays set.
- R4: Control bit 1 (done) is set by a `k_done` pulse. In the sequential variant (CHAINED=0), a read of 0x0 returns the set value and clears the bit.
- R5: Control bit 2 returns `k_idle` and bit 3 returns `k_ready`, sampled when the read is accepted. Control bits 4, 5, 6 and 8 to 31 read 0.
- R6: In the chained variant (CHAINED=1), a write to 0x0 with bit 4 set clears done and drives `k_continue` high for exactly one cycle after the accepting edge. Reads do not clear done. In the sequential variant, bit 4 has no effect and `k_continue` stays low.
- R7: Bit 0 of 0x4 (global enable) and bit 0 of 0x8 (source enable) are read/write, and their other bits read 0. `irq` is high exactly when both enables and the status bit are 1.
- R8: Bit 0 of 0xC (status) is set by a `k_done` pulse. Writing it with data bit 0 equal to 1 toggles it, and writing 0 leaves it unchanged.
- R9: Argument words start at 0x10. Scalar i sits at 0x10+4i. Buffer j has its low word at 0x10+4*N_SCALAR+8j and its high word 4 bytes above that. Each word is read/write with per-byte strobes and drives the matching slice of `arg_scalar` or `arg_buf`.
- R10: Word addresses past the last argument word read 0, and writes to them change no register.
- R11: Every write response and read response is OKAY (0). Only one write and one read are in flight at a time: `s_awready` is low while `s_bvalid` is pending, `s_bvalid` holds until `s_bready`, and `s_rvalid` holds with stable `s_rdata` until `s_rready`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Control clock |
| rst_n | input | 1 | Active-low synchronous reset |
| s_awvalid | input | 1 | Write address valid |
| s_awready | output | 1 | Write address ready |
| s_awaddr | input | ADDR_W | Write byte address |
| s_wvalid | input | 1 | Write data valid |
| s_wready | output | 1 | Write data ready |
| s_wdata | input | 32 | Write data |
| s_wstrb | input | 4 | Write byte strobes |
| s_bvalid | output | 1 | Write response valid |
| s_bready | input | 1 | Write response ready |
| s_bresp | output | 2 | Write response code |
| s_arvalid | input | 1 | Read address valid |
| s_arready | output | 1 | Read address ready |
| s_araddr | input | ADDR_W | Read byte address |
| s_rvalid | output | 1 | Read data valid |
| s_rready | input | 1 | Read data ready |
| s_rdata | output | 32 | Read data |
| s_rresp | output | 2 | Read response code |
| k_start | output | 1 | Start level to the kernel |
| k_continue | output | 1 | One-cycle continue pulse to the kernel |
| k_done | input | 1 | Completion pulse from the kernel |
| k_idle | input | 1 | Kernel idle level |
| k_ready | input | 1 | Kernel ready level |
| arg_scalar | output | 32*N_SCALAR | Scalar argument values |
| arg_buf | output | 64*N_BUFFER | Buffer offset argument values |
| irq | output | 1 | Active-high interrupt |

## Verification
The argument words are swept with all sixteen byte-strobe patterns and a data value that changes on every write. This separates correct lane merging from lane swaps, from writes that ignore the strobes, and from writes that land on the wrong word. Every unmapped word address is written with all ones and then read. This shows whether writes leak into real registers and whether the unused part of the read mux returns zero. The handshake is exercised with both variants side by side under the same stimulus: start with and without auto-restart, reads and continue writes after done, and status toggles against every enable combination. This shows whether done is cleared by the read or by the continue write. Held responses with a late `s_bready` or `s_rready` show whether a second write is refused and whether read data stays put.

// File: rtl/accel_ctrl_pkg.sv
package accel_ctrl_pkg;
   // word indices of the fixed registers (byte address / 4)
   localparam int WORD_CTRL = 0;
   localparam int WORD_GLOB = 1;
   localparam int WORD_SRCE = 2;
   localparam int WORD_STAT = 3;
   localparam int WORD_ARG0 = 4;

   localparam logic [1:0] RESP_OKAY = 2'b00;

   typedef struct packed {
      logic go;
      logic fin;
      logic auto_rs;
   } run_state_t;

   function automatic logic [31:0] ctrl_word(input run_state_t st, input logic idle, input logic rdy);
      logic [31:0] w;
      w    = '0;
      w[0] = st.go;
      w[1] = st.fin;
      w[2] = idle;
      w[3] = rdy;
      w[7] = st.auto_rs;
      return w;
   endfunction
endpackage

// File: rtl/accel_ctrl_axil.sv
module accel_ctrl_axil #(
   parameter int ADDR_W = 8,
   localparam int IDX_W = ADDR_W - 2
) (
   input  logic              clk,
   input  logic              rst_q,
   input  logic              awvalid,
   input  logic [ADDR_W-1:0] awaddr,
   input  logic              wvalid,
   input  logic              bready,
   input  logic              arvalid,
   input  logic [ADDR_W-1:0] araddr,
   input  logic              rready,
   input  logic [31:0]       rd_word,
   output logic              awready,
   output logic              wready,
   output logic              bvalid,
   output logic              arready,
   output logic              rvalid,
   output logic [31:0]       rdata,
   output logic              wr_en,
   output logic [IDX_W-1:0]  wr_idx,
   output logic              rd_en,
   output logic [IDX_W-1:0]  rd_idx
);
   logic bvalid_q, rvalid_q;
   logic [31:0] rdata_q;
   logic unused_addr_lsbs;

   assign wr_en   = awvalid && wvalid && !bvalid_q;
   assign awready = wr_en;
   assign wready  = wr_en;
   assign wr_idx  = awaddr[ADDR_W-1:2];

   assign arready = !rvalid_q;
   assign rd_en   = arvalid && !rvalid_q;
   assign rd_idx  = araddr[ADDR_W-1:2];

   assign unused_addr_lsbs = ^{awaddr[1:0], araddr[1:0]};

   always_ff @(posedge clk) begin
      if (!rst_q) begin
         bvalid_q <= 1'b0;
         rvalid_q <= 1'b0;
         rdata_q  <= '0;
      end else begin
         if (wr_en)       bvalid_q <= 1'b1;
         else if (bready) bvalid_q <= 1'b0;
         if (rd_en) begin
            rvalid_q <= 1'b1;
            rdata_q  <= rd_word;
         end else if (rready) begin
            rvalid_q <= 1'b0;
         end
      end
   end

   assign bvalid = bvalid_q;
   assign rvalid = rvalid_q;
   assign rdata  = rdata_q;
endmodule

// File: rtl/accel_ctrl_core.sv
module accel_ctrl_core
   import accel_ctrl_pkg::*;
#(
   parameter int IDX_W   = 6,
   parameter bit CHAINED = 1'b0
) (
   input  logic             clk,
   input  logic             rst_q,
   input  logic             wr_en,
   input  logic [IDX_W-1:0] wr_idx,
   input  logic             wr_strb0,
   input  logic             wr_b0,
   input  logic             wr_b4,
   input  logic             wr_b7,
   input  logic             rd_en,
   input  logic [IDX_W-1:0] rd_idx,
   input  logic             k_done,
   input  logic             k_idle,
   input  logic             k_ready,
   output logic             k_start,
   output logic             k_continue,
   output logic             irq,
   output logic [31:0]      rd_word
);
   run_state_t st_q;
   logic glob_q, srce_q, stat_q;
   logic wr_ctrl, wr_glob, wr_srce, wr_stat, rd_ctrl, fin_clr;

   assign wr_ctrl = wr_en && wr_strb0 && (wr_idx == IDX_W'(WORD_CTRL));
   assign wr_glob = wr_en && wr_strb0 && (wr_idx == IDX_W'(WORD_GLOB));
   assign wr_srce = wr_en && wr_strb0 && (wr_idx == IDX_W'(WORD_SRCE));
   assign wr_stat = wr_en && wr_strb0 && (wr_idx == IDX_W'(WORD_STAT));
   assign rd_ctrl = rd_en && (rd_idx == IDX_W'(WORD_CTRL));

   generate
      if (CHAINED) begin : g_chain
         logic cont_q;
         assign fin_clr = wr_ctrl && wr_b4;
         always_ff @(posedge clk) begin
            if (!rst_q) cont_q <= 1'b0;
            else        cont_q <= wr_ctrl && wr_b4;
         end
         assign k_continue = cont_q;
      end else begin : g_seq
         logic unused_cont;
         assign unused_cont = wr_b4;
         assign fin_clr     = rd_ctrl;
         assign k_continue  = 1'b0;
      end
   endgenerate

   always_ff @(posedge clk) begin
      if (!rst_q) begin
         st_q   <= '0;
         glob_q <= 1'b0;
         srce_q <= 1'b0;
         stat_q <= 1'b0;
      end else begin
         if (wr_ctrl && wr_b0)            st_q.go <= 1'b1;
         else if (k_done && !st_q.auto_rs) st_q.go <= 1'b0;
         if (k_done)       st_q.fin <= 1'b1;
         else if (fin_clr) st_q.fin <= 1'b0;
         if (wr_ctrl) st_q.auto_rs <= wr_b7;
         if (wr_glob) glob_q <= wr_b0;
         if (wr_srce) srce_q <= wr_b0;
         stat_q <= (stat_q ^ (wr_stat && wr_b0)) | k_done;
      end
   end

   assign k_start = st_q.go;
   assign irq     = glob_q && srce_q && stat_q;

   always_comb begin
      rd_word = '0;
      if (rd_idx == IDX_W'(WORD_CTRL))      rd_word = ctrl_word(st_q, k_idle, k_ready);
      else if (rd_idx == IDX_W'(WORD_GLOB)) rd_word[0] = glob_q;
      else if (rd_idx == IDX_W'(WORD_SRCE)) rd_word[0] = srce_q;
      else if (rd_idx == IDX_W'(WORD_STAT)) rd_word[0] = stat_q;
   end
endmodule

// File: rtl/accel_ctrl_args.sv
module accel_ctrl_args
   import accel_ctrl_pkg::*;
#(
   parameter int N_SCALAR = 4,
   parameter int N_BUFFER = 2,
   parameter int IDX_W    = 6,
   localparam int N_WORDS = N_SCALAR + 2 * N_BUFFER
) (
   input  logic                  clk,
   input  logic                  rst_q,
   input  logic                  wr_en,
   input  logic [IDX_W-1:0]      wr_idx,
   input  logic [31:0]           wr_data,
   input  logic [3:0]            wr_strb,
   input  logic [IDX_W-1:0]      rd_idx,
   output logic [31:0]           rd_word,
   output logic [32*N_SCALAR-1:0] arg_scalar,
   output logic [64*N_BUFFER-1:0] arg_buf
);
   logic [N_WORDS-1:0][31:0] words;

   generate
      for (genvar w = 0; w < N_WORDS; w++) begin : g_word
         logic [31:0] word_q;
         logic        hit;
         assign hit = wr_en && (wr_idx == IDX_W'(WORD_ARG0 + w));
         always_ff @(posedge clk) begin
            if (!rst_q) begin
               word_q <= '0;
            end else if (hit) begin
               for (int b = 0; b < 4; b++)
                  if (wr_strb[b]) word_q[8*b +: 8] <= wr_data[8*b +: 8];
            end
         end
         assign words[w] = word_q;
      end
      for (genvar i = 0; i < N_SCALAR; i++) begin : g_scalar
         assign arg_scalar[32*i +: 32] = words[i];
      end
      for (genvar j = 0; j < N_BUFFER; j++) begin : g_buf
         assign arg_buf[64*j +: 64] = {words[N_SCALAR + 2*j + 1], words[N_SCALAR + 2*j]};
      end
   endgenerate

   always_comb begin
      rd_word = '0;
      for (int w = 0; w < N_WORDS; w++)
         if (rd_idx == IDX_W'(WORD_ARG0 + w)) rd_word = words[w];
   end
endmodule

// File: rtl/accel_ctrl_slave.sv
module accel_ctrl_slave
   import accel_ctrl_pkg::*;
#(
   parameter int ADDR_W   = 8,
   parameter int N_SCALAR = 4,
   parameter int N_BUFFER = 2,
   parameter bit CHAINED  = 1'b0,
   localparam int IDX_W   = ADDR_W - 2,
   localparam int N_WORDS = N_SCALAR + 2 * N_BUFFER,
   localparam int NEED_W  = $clog2(4 * (WORD_ARG0 + N_WORDS))
) (
   input  logic                   clk,
   input  logic                   rst_n,
   input  logic                   s_awvalid,
   output logic                   s_awready,
   input  logic [ADDR_W-1:0]      s_awaddr,
   input  logic                   s_wvalid,
   output logic                   s_wready,
   input  logic [31:0]            s_wdata,
   input  logic [3:0]             s_wstrb,
   output logic                   s_bvalid,
   input  logic                   s_bready,
   output logic [1:0]             s_bresp,
   input  logic                   s_arvalid,
   output logic                   s_arready,
   input  logic [ADDR_W-1:0]      s_araddr,
   output logic                   s_rvalid,
   input  logic                   s_rready,
   output logic [31:0]            s_rdata,
   output logic [1:0]             s_rresp,
   output logic                   k_start,
   output logic                   k_continue,
   input  logic                   k_done,
   input  logic                   k_idle,
   input  logic                   k_ready,
   output logic [32*N_SCALAR-1:0] arg_scalar,
   output logic [64*N_BUFFER-1:0] arg_buf,
   output logic                   irq
);
   generate
      if (N_SCALAR < 1 || N_BUFFER < 1) begin : g_bad_count
         $error("accel_ctrl_slave: N_SCALAR and N_BUFFER must each be at least 1");
      end
      if (ADDR_W < NEED_W) begin : g_bad_addr
         $error("accel_ctrl_slave: ADDR_W too narrow for the register map");
      end
   endgenerate

   logic rst_q;
   always_ff @(posedge clk) rst_q <= rst_n;

   logic             wr_en, rd_en;
   logic [IDX_W-1:0] wr_idx, rd_idx;
   logic [31:0]      core_word, arg_word, rd_word;

   assign rd_word = core_word | arg_word;
   assign s_bresp = RESP_OKAY;
   assign s_rresp = RESP_OKAY;

   accel_ctrl_axil #(.ADDR_W(ADDR_W)) u_axil (
      .clk(clk), .rst_q(rst_q),
      .awvalid(s_awvalid), .awaddr(s_awaddr), .wvalid(s_wvalid), .bready(s_bready),
      .arvalid(s_arvalid), .araddr(s_araddr), .rready(s_rready), .rd_word(rd_word),
      .awready(s_awready), .wready(s_wready), .bvalid(s_bvalid),
      .arready(s_arready), .rvalid(s_rvalid), .rdata(s_rdata),
      .wr_en(wr_en), .wr_idx(wr_idx), .rd_en(rd_en), .rd_idx(rd_idx)
   );

   accel_ctrl_core #(.IDX_W(IDX_W), .CHAINED(CHAINED)) u_core (
      .clk(clk), .rst_q(rst_q),
      .wr_en(wr_en), .wr_idx(wr_idx), .wr_strb0(s_wstrb[0]),
      .wr_b0(s_wdata[0]), .wr_b4(s_wdata[4]), .wr_b7(s_wdata[7]),
      .rd_en(rd_en), .rd_idx(rd_idx),
      .k_done(k_done), .k_idle(k_idle), .k_ready(k_ready),
      .k_start(k_start), .k_continue(k_continue), .irq(irq), .rd_word(core_word)
   );

   accel_ctrl_args #(.N_SCALAR(N_SCALAR), .N_BUFFER(N_BUFFER), .IDX_W(IDX_W)) u_args (
      .clk(clk), .rst_q(rst_q),
      .wr_en(wr_en), .wr_idx(wr_idx), .wr_data(s_wdata), .wr_strb(s_wstrb),
      .rd_idx(rd_idx), .rd_word(arg_word),
      .arg_scalar(arg_scalar), .arg_buf(arg_buf)
   );
endmodule

// File: rtl/accel_ctrl_slave_chk.sv
module accel_ctrl_slave_chk (
   input logic        clk,
   input logic        rst_q,
   input logic        aw_hs,
   input logic        k_start,
   input logic        k_done,
   input logic        k_continue,
   input logic        irq,
   input logic        awready,
   input logic        bvalid,
   input logic        bready,
   input logic        rvalid,
   input logic        rready,
   input logic [31:0] rdata
);
   // R2
   start_rise_chk: assert property (@(posedge clk) disable iff (rst_q !== 1'b1)
      $rose(k_start) |-> $past(aw_hs));
   // R3
   start_fall_chk: assert property (@(posedge clk) disable iff (rst_q !== 1'b1)
      $fell(k_start) |-> $past(k_done));
   // R6
   cont_pulse_chk: assert property (@(posedge clk) disable iff (rst_q !== 1'b1)
      k_continue |=> !k_continue);
   // R6
   cont_src_chk: assert property (@(posedge clk) disable iff (rst_q !== 1'b1)
      k_continue |-> $past(aw_hs));
   // R7
   irq_rise_chk: assert property (@(posedge clk) disable iff (rst_q !== 1'b1)
      $rose(irq) |-> $past(aw_hs || k_done));
   // R11
   b_hold_chk: assert property (@(posedge clk) disable iff (rst_q !== 1'b1)
      bvalid && !bready |=> bvalid);
   // R11
   r_hold_chk: assert property (@(posedge clk) disable iff (rst_q !== 1'b1)
      rvalid && !rready |=> rvalid && $stable(rdata));
   // R11
   one_write_chk: assert property (@(posedge clk) disable iff (rst_q !== 1'b1)
      bvalid |-> !awready);
endmodule

bind accel_ctrl_slave accel_ctrl_slave_chk u_chk (
   .clk(clk), .rst_q(rst_q), .aw_hs(wr_en),
   .k_start(k_start), .k_done(k_done), .k_continue(k_continue), .irq(irq),
   .awready(s_awready), .bvalid(s_bvalid), .bready(s_bready),
   .rvalid(s_rvalid), .rready(s_rready), .rdata(s_rdata)
);

// File: tb/accel_ctrl_slave_bench.sv
`timescale 1ns/1ps
module accel_ctrl_slave_bench;
   localparam int AW = 6;
   localparam int NS = 2;
   localparam int NB = 2;
   localparam int NW = NS + 2 * NB;

   logic clk = 1'b0;
   always #10 clk = ~clk;

   logic rst_n = 1'b0;
   logic awvalid = 0, wvalid = 0, bready = 0, arvalid = 0, rready = 0;
   logic [AW-1:0] awaddr = '0, araddr = '0;
   logic [31:0] wdata = '0;
   logic [3:0]  wstrb = '0;
   logic k_done = 0, k_idle = 1, k_ready = 0;

   logic awready_s, wready_s, bvalid_s, arready_s, rvalid_s, kstart_s, kcont_s, irq_s;
   logic awready_c, wready_c, bvalid_c, arready_c, rvalid_c, kstart_c, kcont_c, irq_c;
   logic [1:0] bresp_s, rresp_s, bresp_c, rresp_c;
   logic [31:0] rdata_s, rdata_c;
   logic [32*NS-1:0] scal_s, scal_c;
   logic [64*NB-1:0] buf_s, buf_c;

   accel_ctrl_slave #(.ADDR_W(AW), .N_SCALAR(NS), .N_BUFFER(NB), .CHAINED(1'b0)) u_accel_ctrl_slave (
      .clk(clk), .rst_n(rst_n),
      .s_awvalid(awvalid), .s_awready(awready_s), .s_awaddr(awaddr),
      .s_wvalid(wvalid), .s_wready(wready_s), .s_wdata(wdata), .s_wstrb(wstrb),
      .s_bvalid(bvalid_s), .s_bready(bready), .s_bresp(bresp_s),
      .s_arvalid(arvalid), .s_arready(arready_s), .s_araddr(araddr),
      .s_rvalid(rvalid_s), .s_rready(rready), .s_rdata(rdata_s), .s_rresp(rresp_s),
      .k_start(kstart_s), .k_continue(kcont_s), .k_done(k_done), .k_idle(k_idle), .k_ready(k_ready),
      .arg_scalar(scal_s), .arg_buf(buf_s), .irq(irq_s)
   );

   accel_ctrl_slave #(.ADDR_W(AW), .N_SCALAR(NS), .N_BUFFER(NB), .CHAINED(1'b1)) u_accel_ctrl_slave_chain (
      .clk(clk), .rst_n(rst_n),
      .s_awvalid(awvalid), .s_awready(awready_c), .s_awaddr(awaddr),
      .s_wvalid(wvalid), .s_wready(wready_c), .s_wdata(wdata), .s_wstrb(wstrb),
      .s_bvalid(bvalid_c), .s_bready(bready), .s_bresp(bresp_c),
      .s_arvalid(arvalid), .s_arready(arready_c), .s_araddr(araddr),
      .s_rvalid(rvalid_c), .s_rready(rready), .s_rdata(rdata_c), .s_rresp(rresp_c),
      .k_start(kstart_c), .k_continue(kcont_c), .k_done(k_done), .k_idle(k_idle), .k_ready(k_ready),
      .arg_scalar(scal_c), .arg_buf(buf_c), .irq(irq_c)
   );

   int checks = 0;
   int errors = 0;
   logic cont_s, cont_c;
   logic [31:0] rs, rc;
   logic [31:0] exp_arg [NW];

   task automatic chk(input string tag, input logic [63:0] act, input logic [63:0] exp);
      checks++;
      if (act !== exp) begin
         errors++;
         $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
      end
   endtask

   task automatic axw(input logic [AW-1:0] a, input logic [31:0] d, input logic [3:0] s);
      @(negedge clk);
      awaddr = a; wdata = d; wstrb = s; awvalid = 1; wvalid = 1;
      @(posedge clk);
      @(negedge clk);
      awvalid = 0; wvalid = 0;
      cont_s = kcont_s; cont_c = kcont_c;
      chk("R11 bvalid", {bvalid_s, bvalid_c}, 2'b11);
      chk("R11 bresp", {bresp_s, bresp_c}, 0);
      bready = 1;
      @(negedge clk);
      bready = 0;
   endtask

   task automatic axr(input logic [AW-1:0] a);
      @(negedge clk);
      araddr = a; arvalid = 1;
      @(posedge clk);
      @(negedge clk);
      arvalid = 0;
      chk("R11 rvalid", {rvalid_s, rvalid_c}, 2'b11);
      chk("R11 rresp", {rresp_s, rresp_c}, 0);
      rs = rdata_s; rc = rdata_c;
      rready = 1;
      @(negedge clk);
      rready = 0;
   endtask

   task automatic pulse_done();
      @(negedge clk); k_done = 1;
      @(negedge clk); k_done = 0;
   endtask

   function automatic logic [31:0] out_word(input int w);
      if (w < NS) return scal_s[32*w +: 32];
      return buf_s[64*((w-NS)/2) + 32*((w-NS)%2) +: 32];
   endfunction

   initial begin
      repeat (100000) @(posedge clk);
      errors++;
      $display("FAIL watchdog actual=running expected=finished");
      $display("  CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
   end

   initial begin
      repeat (5) @(negedge clk);
      rst_n = 1;
      repeat (2) @(negedge clk);

      // R1 reset state
      chk("R1 outputs", {kstart_s, kstart_c, kcont_s, kcont_c, irq_s, irq_c}, 0);
      chk("R1 scalars", scal_s, 0);
      chk("R1 buffers", buf_s, 0);
      axr(0);  chk("R1 ctrl seq", rs, 32'h4); chk("R1 ctrl chain", rc, 32'h4);
      axr(4);  chk("R1 glob", {rs, rc}, 0);
      axr(8);  chk("R1 srce", {rs, rc}, 0);
      axr(12); chk("R1 stat", {rs, rc}, 0);

      // R5 live idle/ready
      k_idle = 0; k_ready = 1;
      axr(0); chk("R5 ready only", {rs, rc}, {32'h8, 32'h8});
      k_idle = 1; k_ready = 0;

      // R2 start
      axw(0, 32'h0, 4'hF); chk("R2 write zero no start", {kstart_s, kstart_c}, 0);
      axw(0, 32'h1, 4'hE); chk("R2 strobe off no start", {kstart_s, kstart_c}, 0);
      axw(0, 32'hFFFF_FF6D, 4'h1); chk("R2 start set", {kstart_s, kstart_c}, 2'b11);
      axr(0); chk("R5 reserved zero with start", {rs, rc}, {32'h5, 32'h5});

      // R3 / R4 / R6 done handling
      pulse_done();
      chk("R3 start cleared by done", {kstart_s, kstart_c}, 0);
      axr(0); chk("R4 done seen seq", rs, 32'h6); chk("R6 done seen chain", rc, 32'h6);
      axr(0); chk("R4 done cleared by read", rs, 32'h4); chk("R6 read keeps done", rc, 32'h6);
      axw(0, 32'h10, 4'h1);
      chk("R6 continue pulse chain", cont_c, 1);
      chk("R6 continue none seq", cont_s, 0);
      chk("R6 continue single cycle", {kcont_s, kcont_c}, 0);
      axr(0); chk("R6 continue clears done", {rs, rc}, {32'h4, 32'h4});

      // R8 / R7 interrupt
      axr(12); chk("R8 status set by done", {rs, rc}, {32'h1, 32'h1});
      chk("R7 irq off no enables", {irq_s, irq_c}, 0);
      axw(4, 32'hFFFF_FFFF, 4'hF);
      axr(4); chk("R7 glob readback", {rs, rc}, {32'h1, 32'h1});
      chk("R7 irq off srce clear", {irq_s, irq_c}, 0);
      axw(8, 32'hFFFF_FFFF, 4'hF);
      axr(8); chk("R7 srce readback", {rs, rc}, {32'h1, 32'h1});
      chk("R7 irq on all set", {irq_s, irq_c}, 2'b11);
      axw(4, 32'h0, 4'hF); chk("R7 irq off glob clear", {irq_s, irq_c}, 0);
      axw(4, 32'h1, 4'h1); chk("R7 irq back on", {irq_s, irq_c}, 2'b11);
      axw(12, 32'h0, 4'hF); chk("R8 write zero keeps", {irq_s, irq_c}, 2'b11);
      axw(12, 32'h1, 4'h1); chk("R8 toggle clears", {irq_s, irq_c}, 0);
      axr(12); chk("R8 status cleared", {rs, rc}, 0);
      axw(12, 32'h1, 4'h1); chk("R8 toggle sets", {irq_s, irq_c}, 2'b11);
      axw(12, 32'h1, 4'h1); chk("R8 toggle clears again", {irq_s, irq_c}, 0);

      // R3 auto-restart
      axw(0, 32'h81, 4'h1);
      axr(0); chk("R3 auto readback", {rs, rc}, {32'h85, 32'h85});
      pulse_done();
      chk("R3 auto keeps start", {kstart_s, kstart_c}, 2'b11);
      chk("R8 done sets irq", {irq_s, irq_c}, 2'b11);
      axr(0); chk("R3 auto done read", {rs, rc}, {32'h87, 32'h87});
      axw(0, 32'h0, 4'h1);
      pulse_done();
      chk("R3 start clears without auto", {kstart_s, kstart_c}, 0);

      // R9 argument strobe sweep
      for (int w = 0; w < NW; w++) exp_arg[w] = '0;
      for (int w = 0; w < NW; w++) begin
         for (int s = 0; s < 16; s++) begin
            logic [31:0] d;
            d = 32'h9E37_79B9 * (w * 16 + s + 1);
            axw(AW'(16 + 4 * w), d, 4'(s));
            for (int b = 0; b < 4; b++)
               if (s[b]) exp_arg[w][8*b +: 8] = d[8*b +: 8];
            axr(AW'(16 + 4 * w));
            chk("R9 arg readback", {rs, rc}, {exp_arg[w], exp_arg[w]});
            chk("R9 arg output", out_word(w), exp_arg[w]);
         end
      end

      // R10 unmapped words
      for (int i = 4 + NW; i < 16; i++) axw(AW'(4 * i), 32'hFFFF_FFFF, 4'hF);
      for (int i = 4 + NW; i < 16; i++) begin
         axr(AW'(4 * i)); chk("R10 unmapped reads zero", {rs, rc}, 0);
      end
      for (int w = 0; w < NW; w++) begin
         axr(AW'(16 + 4 * w)); chk("R10 args untouched", rs, exp_arg[w]);
         chk("R10 arg output untouched", out_word(w), exp_arg[w]);
      end
      axr(0); chk("R10 ctrl untouched", {rs, rc}, {32'h6, 32'h6});

      // R11 held write response blocks a second write
      @(negedge clk);
      awaddr = 6'h10; wdata = 32'h1111_2222; wstrb = 4'hF; awvalid = 1; wvalid = 1;
      @(posedge clk);
      @(negedge clk);
      wdata = 32'h3333_4444;
      for (int k = 0; k < 3; k++) begin
         chk("R11 bvalid held", bvalid_s, 1);
         chk("R11 awready blocked", {awready_s, awready_c}, 0);
         @(negedge clk);
      end
      bready = 1;
      @(negedge clk);
      bready = 0;
      chk("R11 awready after response", awready_s, 1);
      @(negedge clk);
      awvalid = 0; wvalid = 0; bready = 1;
      @(negedge clk);
      bready = 0;
      exp_arg[0] = 32'h3333_4444;

      // R11 held read data
      @(negedge clk);
      araddr = 6'h10; arvalid = 1;
      @(posedge clk);
      @(negedge clk);
      arvalid = 0;
      rs = rdata_s;
      for (int k = 0; k < 3; k++) begin
         chk("R11 rvalid held", rvalid_s, 1);
         chk("R11 rdata stable", rdata_s, rs);
         chk("R11 arready blocked", arready_s, 0);
         @(negedge clk);
      end
      rready = 1;
      @(negedge clk);
      rready = 0;
      chk("R11 second write landed", rs, exp_arg[0]);
      chk("R9 scalar0 output", scal_s[31:0], exp_arg[0]);

      $display("  CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
   end
endmodule